// File: doc/BRIEF.md
# Latched Priority Interrupt Controller

This block gathers interrupt requests from several peripheral sources and presents the most urgent one to a CPU. Each channel owns a small control register with a priority level, an enable bit and a request latch. A rising edge on a channel's source input sets its latch whether or not the channel is enabled. The latch stays set until software changes it with a write that carries a detect qualifier. A qualified write can clear the latch or set it, and the same write can also change the enable bit.

The CPU supplies its current interrupt mask level. An acknowledge register reports the winning channel number multiplied by four. The winner is chosen among channels that are enabled, pending and strictly more urgent than the mask. The interrupt output follows the same decision with no register delay. Reading the acknowledge register changes nothing. Channel 0 is reserved, so an acknowledge value of zero always means that no channel qualifies.

Top module: `latchedIrqCtrl`

## Requirements
- R1: A synchronous active-high reset clears every level, enable and request latch. After reset every register reads 0, the acknowledge register reads 0 and irqOut is low.
- R2: Bus address c, for 1 <= c < NUM_CH, selects channel c's control register. Its bits are: [2:0] level, [3] enable, [4] request, [5] detect. Detect is write-only and reads 0, and so do bits [7:6]. Address NUM_CH is the read-only acknowledge register. Any other address reads 0.
- R3: A rising edge on srcReq[c] sets channel c's latch at the next clock edge, even while the channel is disabled. A source that is held high does not set the latch again after it has been cleared.
- R4: A set latch stays set after its source input deasserts.
- R5: A write with detect=1 loads the latch from data bit 4, so it can either clear or set the latch. A write with detect=0 updates level and enable and leaves the latch as it was.
- R6: One write with enable=1, detect=1 and request=0 enables the channel and clears its latch in the same cycle.
- R7: When a rising source edge and a latch-clearing write reach the same channel in the same cycle, the latch ends up set.
- R8: The acknowledge register returns channel*4 for the winning channel, or 0 when no channel qualifies. A channel qualifies when it is enabled, its latch is set and its level is numerically below cpuMask. A cpuMask of 0 therefore blocks every channel.
- R9: Level 0 is the most urgent. Among qualifying channels the lowest level wins, and a tie goes to the lowest channel number.
- R10: Channel 0 ignores its source input and all writes. Its register always reads 0, and it is never reported.
- R11: irqOut is high exactly when the acknowledge register would read a nonzero value. It follows input changes within the same cycle.
- R12: Reading the acknowledge register has no side effect, so repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srcReq | input | NUM_CH | Peripheral request inputs, one per channel, rising-edge sensitive |
| busAddr | input | ADDR_W | Register address (channels, then the acknowledge register) |
| busWrEn | input | 1 | Write strobe, sampled on the clock edge |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data for busAddr |
| cpuMask | input | LVL_W | CPU's current interrupt mask level |
| irqOut | output | 1 | Interrupt request to the CPU |

## Verification
The hardest case to reach from the ports is a source edge that arrives in the same clock cycle as a qualified write that clears the latch. The bench drives the source and the write strobe on the same falling edge, so that both are seen by one rising edge. It then reads the register back to confirm that the event was kept. A second hard case is a source held high through a clear. This one is reached by raising the input, clearing the latch while the input stays high for several cycles, and then reading the request bit.

// File: rtl/picPkg.sv
package picPkg;
  localparam int LVL_W   = 3;
  localparam int DATA_W  = 8;
  localparam int EN_BIT  = 3;
  localparam int REQ_BIT = 4;
  localparam int DET_BIT = 5;

  typedef struct packed {
    logic             wrStrobe;
    logic             ackSel;
    logic             chRead;
    logic [LVL_W-1:0] wrLevel;
    logic             wrEnable;
    logic             wrRequest;
    logic             wrDetect;
  } picStrobeT;
endpackage

// File: rtl/picCtrl.sv
module picCtrl
  import picPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = $clog2(NUM_CH + 1),
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output picStrobeT         strobe,
  output logic [NUM_CH-1:0] chSel,
  output logic [IDX_W-1:0]  rdIdx
);
  localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(NUM_CH);

  logic addrIsCh;
  assign addrIsCh = (busAddr < ACK_ADDR) && (busAddr != '0);

  always_comb begin
    strobe.wrStrobe  = busWrEn && addrIsCh;
    strobe.ackSel    = (busAddr == ACK_ADDR);
    strobe.chRead    = addrIsCh;
    strobe.wrLevel   = busWrData[LVL_W-1:0];
    strobe.wrEnable  = busWrData[EN_BIT];
    strobe.wrRequest = busWrData[REQ_BIT];
    strobe.wrDetect  = busWrData[DET_BIT];
  end

  assign rdIdx = addrIsCh ? IDX_W'(busAddr) : '0;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : gSel
      if (c == 0) begin : gRsv
        assign chSel[c] = 1'b0;
      end else begin : gLive
        assign chSel[c] = busWrEn && (busAddr == ADDR_W'(c));
      end
    end
  endgenerate
endmodule

// File: rtl/picArbiter.sv
module picArbiter
  import picPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]            cand,
  input  logic [NUM_CH-1:0][LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0]             cpuMask,
  output logic                         found,
  output logic [IDX_W-1:0]             bestIdx
);
  logic [LVL_W-1:0] bestLvl;

  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestLvl = '1;
    for (int c = 1; c < NUM_CH; c++) begin
      if (cand[c] && (lvl[c] < cpuMask) && (!found || (lvl[c] < bestLvl))) begin
        found   = 1'b1;
        bestLvl = lvl[c];
        bestIdx = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/picDatapath.sv
module picDatapath
  import picPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] srcReq,
  input  picStrobeT         strobe,
  input  logic [NUM_CH-1:0] chSel,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [LVL_W-1:0]  cpuMask,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);
  logic [NUM_CH-1:0]            reqLatch;
  logic [NUM_CH-1:0]            enBits;
  logic [NUM_CH-1:0]            prevReq;
  logic [NUM_CH-1:0][LVL_W-1:0] lvlRegs;
  logic                         found;
  logic [IDX_W-1:0]             bestIdx;
  logic [DATA_W-1:0]            ackVal;
  logic [DATA_W-1:0]            chVal;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : gCh
      if (c == 0) begin : gRsv
        assign reqLatch[c] = 1'b0;
        assign enBits[c]   = 1'b0;
        assign prevReq[c]  = 1'b0;
        assign lvlRegs[c]  = '0;
      end else begin : gLive
        logic riseEv;
        logic latchNext;
        assign riseEv    = srcReq[c] && !prevReq[c];
        assign latchNext = (chSel[c] && strobe.wrDetect) ? strobe.wrRequest : reqLatch[c];

        always_ff @(posedge clk) begin
          if (rst) begin
            prevReq[c]  <= 1'b0;
            reqLatch[c] <= 1'b0;
            enBits[c]   <= 1'b0;
            lvlRegs[c]  <= '0;
          end else begin
            prevReq[c]  <= srcReq[c];
            reqLatch[c] <= latchNext || riseEv;
            if (chSel[c]) begin
              enBits[c]  <= strobe.wrEnable;
              lvlRegs[c] <= strobe.wrLevel;
            end
          end
        end
      end
    end
  endgenerate

  picArbiter #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) uArb (
    .cand    (reqLatch & enBits),
    .lvl     (lvlRegs),
    .cpuMask (cpuMask),
    .found   (found),
    .bestIdx (bestIdx)
  );

  assign ackVal = found ? DATA_W'({bestIdx, 2'b00}) : '0;
  assign irqOut = found;

  always_comb begin
    chVal = '0;
    chVal[LVL_W-1:0] = lvlRegs[rdIdx];
    chVal[EN_BIT]    = enBits[rdIdx];
    chVal[REQ_BIT]   = reqLatch[rdIdx];
  end

  always_comb begin
    if (strobe.ackSel)      busRdData = ackVal;
    else if (strobe.chRead) busRdData = chVal;
    else                    busRdData = '0;
  end
endmodule

// File: rtl/latchedIrqCtrl.sv
module latchedIrqCtrl
  import picPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = $clog2(NUM_CH + 1),
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] srcReq,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [LVL_W-1:0]  cpuMask,
  output logic              irqOut
);
  picStrobeT         strobe;
  logic [NUM_CH-1:0] chSel;
  logic [IDX_W-1:0]  rdIdx;

  picCtrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) uCtrl (
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .strobe    (strobe),
    .chSel     (chSel),
    .rdIdx     (rdIdx)
  );

  picDatapath #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) uDp (
    .clk       (clk),
    .rst       (rst),
    .srcReq    (srcReq),
    .strobe    (strobe),
    .chSel     (chSel),
    .rdIdx     (rdIdx),
    .cpuMask   (cpuMask),
    .busRdData (busRdData),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/latchedIrqCtrlChecker.sv
module latchedIrqCtrlChecker
  import picPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = $clog2(NUM_CH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdData,
  input logic [LVL_W-1:0]  cpuMask,
  input logic              irqOut
);
  localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(NUM_CH);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !irqOut);

  // R8
  ack_align_chk: assert property (@(posedge clk) disable iff (rst)
    (busAddr == ACK_ADDR) |-> (busRdData[1:0] == 2'b00));

  // R11
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    (busAddr == ACK_ADDR) |-> (irqOut == (busRdData != '0)));

  // R8
  mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuMask == '0) |-> !irqOut);

  // R10
  ch0_read_chk: assert property (@(posedge clk) disable iff (rst)
    (busAddr == '0) |-> (busRdData == '0));

  // R2
  detect_read_chk: assert property (@(posedge clk) disable iff (rst)
    (busAddr < ACK_ADDR) |-> (busRdData[DATA_W-1:DET_BIT] == '0));
endmodule

bind latchedIrqCtrl latchedIrqCtrlChecker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .busAddr   (busAddr),
  .busRdData (busRdData),
  .cpuMask   (cpuMask),
  .irqOut    (irqOut)
);

// File: tb/latchedIrqCtrl_test.sv
module latchedIrqCtrl_test;
  localparam int NUM_CH = 8;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_CH-1:0] srcReq = '0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [7:0]        busWrData = '0;
  logic [7:0]        busRdData;
  logic [2:0]        cpuMask = 3'd7;
  logic              irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  latchedIrqCtrl #(.NUM_CH(NUM_CH)) uut (
    .clk(clk), .rst(rst), .srcReq(srcReq), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .cpuMask(cpuMask), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] enc(int lvl, bit en, bit req, bit det);
    return {2'b00, det, req, en, 3'(lvl)};
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(int addr, logic [7:0] data);
    @(negedge clk);
    busAddr = ADDR_W'(addr); busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(int addr, output int val);
    busAddr = ADDR_W'(addr);
    #1;
    val = int'(busRdData);
  endtask

  task automatic pulse(logic [NUM_CH-1:0] bits);
    @(negedge clk); srcReq = srcReq | bits;
    @(negedge clk); srcReq = srcReq & ~bits;
  endtask

  task automatic tReset();
    int v;
    for (int a = 0; a <= NUM_CH; a++) begin
      rdReg(a, v);
      check("R1 reset read", v, 0);
    end
    check("R1 reset irqOut", int'(irqOut), 0);
  endtask

  task automatic tLatchMasked();
    int v;
    wrReg(3, enc(2, 0, 0, 0));
    pulse(8'h08);
    @(negedge clk);
    rdReg(3, v);
    check("R3 R4 latch while disabled", v, int'(enc(2, 0, 1, 0)));
    rdReg(NUM_CH, v);
    check("R8 disabled not reported", v, 0);
    check("R11 irqOut low when disabled", int'(irqOut), 0);
  endtask

  task automatic tNoDetectWrite();
    int v;
    wrReg(3, enc(2, 1, 0, 0));
    rdReg(3, v);
    check("R5 detect=0 keeps latch", v, int'(enc(2, 1, 1, 0)));
    rdReg(NUM_CH, v);
    check("R8 ack ch3", v, 12);
    check("R11 irqOut high", int'(irqOut), 1);
  endtask

  task automatic tMask();
    int v;
    @(negedge clk); cpuMask = 3'd2;
    rdReg(NUM_CH, v);
    check("R8 mask equal blocks", v, 0);
    check("R11 irqOut follows mask", int'(irqOut), 0);
    cpuMask = 3'd3;
    rdReg(NUM_CH, v);
    check("R8 mask above passes", v, 12);
    cpuMask = 3'd7;
  endtask

  task automatic tPriority();
    int v;
    int w;
    wrReg(5, enc(1, 1, 0, 0));
    wrReg(6, enc(1, 1, 0, 0));
    pulse(8'h60);
    rdReg(NUM_CH, v);
    check("R9 lower level and tie to lower channel", v, 20);
    wrReg(7, enc(0, 1, 1, 1));
    rdReg(7, v);
    check("R5 detect sets latch", v, int'(enc(0, 1, 1, 0)));
    rdReg(NUM_CH, v);
    check("R9 level 0 wins", v, 28);
    @(negedge clk);
    rdReg(NUM_CH, w);
    check("R12 repeat ack read", w, v);
    rdReg(7, w);
    check("R12 latch kept after ack read", w, int'(enc(0, 1, 1, 0)));
  endtask

  task automatic tClear();
    int v;
    wrReg(7, enc(0, 1, 0, 1));
    rdReg(7, v);
    check("R5 detect clears latch", v, int'(enc(0, 1, 0, 0)));
    rdReg(NUM_CH, v);
    check("R9 next winner ch5", v, 20);
    wrReg(5, enc(1, 0, 0, 1));
    rdReg(NUM_CH, v);
    check("R9 tie falls to ch6", v, 24);
    wrReg(6, enc(1, 1, 0, 1));
    rdReg(6, v);
    check("R6 enable with clear", v, int'(enc(1, 1, 0, 0)));
    rdReg(NUM_CH, v);
    check("R6 cleared channel not reported", v, 12);
  endtask

  task automatic tHeld();
    int v;
    wrReg(4, enc(4, 1, 0, 0));
    @(negedge clk); srcReq[4] = 1'b1;
    @(negedge clk);
    rdReg(4, v);
    check("R3 rise sets ch4", v, int'(enc(4, 1, 1, 0)));
    wrReg(4, enc(4, 1, 0, 1));
    repeat (3) @(negedge clk);
    rdReg(4, v);
    check("R3 held input does not relatch", v, int'(enc(4, 1, 0, 0)));
    srcReq[4] = 1'b0;
  endtask

  task automatic tCollide();
    int v;
    wrReg(2, enc(3, 0, 0, 0));
    @(negedge clk);
    busAddr = 4'd2; busWrData = enc(3, 0, 0, 1); busWrEn = 1'b1; srcReq[2] = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; srcReq[2] = 1'b0;
    rdReg(2, v);
    check("R7 edge beats clear", v, int'(enc(3, 0, 1, 0)));
  endtask

  task automatic tCh0();
    int v;
    pulse(8'h01);
    wrReg(0, enc(0, 1, 1, 1));
    rdReg(0, v);
    check("R10 ch0 reads zero", v, 0);
    rdReg(NUM_CH, v);
    check("R10 ch0 never reported", v, 12);
    rdReg(NUM_CH + 3, v);
    check("R2 unmapped address reads zero", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tReset();
    tLatchMasked();
    tNoDetectWrite();
    tMask();
    tPriority();
    tClear();
    tHeld();
    tCollide();
    tCh0();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule